// File: doc/BRIEF.md
# Configuration Word Pacing Controller

This block sits in front of a configuration port that can take a new word only once every few clock cycles. It accepts words from one of two producers and presents each one on its output for a fixed number of cycles. One producer is a debug-port stream. The other is an ordinary valid/ready stream. The hold length is the clock-to-data ratio. It follows from two static parameters that describe the bitstream: whether it is compressed and whether it is encrypted. A plain bitstream moves at one word per clock. An encrypted-only bitstream needs two clocks per word. Any compressed bitstream needs four clocks per word, whether or not it is also encrypted.

The debug producer has priority. While its engage input is high, words come only from that producer. The normal stream sees ready held low, so its valid and data inputs have no effect. The choice of producer is made only at a word boundary. A word that is already being held always completes its full hold period, whatever happens to the engage input in the meantime.

Top module: `cfg_word_pacer`

## Requirements
- R1: With both flags clear, the ratio is 1. A continuously valid producer has one word accepted on every clock cycle.
- R2: With only the encrypted flag set, the ratio is 2. A continuously valid producer has one word accepted every 2 cycles.
- R3: With only the compressed flag set, the ratio is 4. A continuously valid producer has one word accepted every 4 cycles.
- R4: With both flags set, the ratio is 4, the same as the compressed-only case.
- R5: A word is accepted at a rising edge. From the next cycle, `cfg_valid` is high and `cfg_data` equals that word for exactly ratio consecutive cycles.
- R6: The selected producer's ready is high exactly when no word is held, or when the held word is in its last hold cycle. A word transfers at a rising edge where both valid and ready are high.
- R7: While `dbg_engaged` is high, words come from `dbg_data`, `s_ready` stays low, and `s_valid` and `s_data` have no effect. While it is low, `dbg_ready` stays low.
- R8: A change of `dbg_engaged` during a hold does not shorten the held word or alter it. The new producer is first used at the next word boundary.
- R9: When the selected producer is not valid at a word boundary, `cfg_valid` goes low after the current word's hold ends, and stays low until a word is accepted.
- R10: A synchronous reset clears the hold counter and drives `cfg_valid` low. Right after reset the selected producer's ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_engaged | input | 1 | Debug producer takes priority while high |
| dbg_valid | input | 1 | Debug producer has a word |
| dbg_data | input | DATA_W | Debug producer word |
| dbg_ready | output | 1 | Debug word is taken at this edge if valid |
| s_valid | input | 1 | Normal stream has a word |
| s_data | input | DATA_W | Normal stream word |
| s_ready | output | 1 | Normal stream word is taken at this edge if valid |
| cfg_data | output | DATA_W | Word presented to the configuration port |
| cfg_valid | output | 1 | High for every cycle of a word's hold period |

## Verification
Several properties are checked on every cycle. Ready never goes to the producer that is not selected. A held word stays stable until its last hold cycle, and the producer it came from does not change mid-hold. Each accepted word reaches the output one cycle later. The counter stays in range. The output is empty after reset. Other behaviour needs the bench's scenarios. These include the actual words-per-clock rate for each of the four flag combinations, the complete ignoring of the normal stream while the debug producer is engaged, and a switch of producer partway through a hold. The bench covers all four flag combinations at once.

// File: rtl/cfg_pace_pkg.sv
package cfg_pace_pkg;

  // Clock cycles each configuration word occupies on the output.
  function automatic int unsigned pace_ratio(input bit compressed, input bit encrypted);
    if (compressed)      return 4;
    else if (encrypted)  return 2;
    else                 return 1;
  endfunction

  // Width of a counter that runs 0 .. ratio-1 (at least one bit).
  function automatic int unsigned pace_cnt_width(input int unsigned ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction

endpackage

// File: rtl/cfg_pace_cnt.sv
module cfg_pace_cnt #(
  parameter int unsigned RATIO = 1,
  parameter int unsigned CNT_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  output logic             busy,
  output logic             hold_last,
  output logic             slot_open,
  output logic [CNT_W-1:0] hold_cnt
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RATIO - 1);

  assign hold_last = busy && (hold_cnt == LAST_IDX);
  assign slot_open = !busy || hold_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      hold_cnt <= '0;
    end else if (slot_open) begin
      busy     <= take;
      hold_cnt <= '0;
    end else begin
      hold_cnt <= hold_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cfg_src_sel.sv
module cfg_src_sel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              dbg_engaged,
  input  logic              dbg_valid,
  input  logic [DATA_W-1:0] dbg_data,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              slot_open,
  output logic              dbg_ready,
  output logic              s_ready,
  output logic              take,
  output logic              take_dbg,
  output logic [DATA_W-1:0] sel_data
);
  logic sel_valid;

  assign sel_valid = dbg_engaged ? dbg_valid : s_valid;
  assign sel_data  = dbg_engaged ? dbg_data  : s_data;
  assign dbg_ready = slot_open &&  dbg_engaged;
  assign s_ready   = slot_open && !dbg_engaged;
  assign take      = slot_open && sel_valid;
  assign take_dbg  = take && dbg_engaged;
endmodule

// File: rtl/cfg_word_hold.sv
module cfg_word_hold #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              take_dbg,
  input  logic [DATA_W-1:0] sel_data,
  output logic [DATA_W-1:0] word_q,
  output logic              src_dbg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= '0;
      src_dbg_q <= 1'b0;
    end else if (take) begin
      word_q    <= sel_data;
      src_dbg_q <= take_dbg;
    end
  end
endmodule

// File: rtl/cfg_word_pacer.sv
module cfg_word_pacer
  import cfg_pace_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter bit          COMPRESSED = 1'b0,
  parameter bit          ENCRYPTED  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_engaged,
  input  logic              dbg_valid,
  input  logic [DATA_W-1:0] dbg_data,
  output logic              dbg_ready,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic [DATA_W-1:0] cfg_data,
  output logic              cfg_valid
);
  localparam int unsigned RATIO = pace_ratio(COMPRESSED, ENCRYPTED);
  localparam int unsigned CNT_W = pace_cnt_width(RATIO);

  // Internal events, named for the checker.
  logic              busy;
  logic              hold_last;
  logic              slot_open;
  logic [CNT_W-1:0]  hold_cnt;
  logic              take;
  logic              take_dbg;
  logic [DATA_W-1:0] sel_data;
  logic              src_dbg_q;

  cfg_pace_cnt #(.RATIO(RATIO), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .busy      (busy),
    .hold_last (hold_last),
    .slot_open (slot_open),
    .hold_cnt  (hold_cnt)
  );

  cfg_src_sel #(.DATA_W(DATA_W)) u_sel (
    .dbg_engaged (dbg_engaged),
    .dbg_valid   (dbg_valid),
    .dbg_data    (dbg_data),
    .s_valid     (s_valid),
    .s_data      (s_data),
    .slot_open   (slot_open),
    .dbg_ready   (dbg_ready),
    .s_ready     (s_ready),
    .take        (take),
    .take_dbg    (take_dbg),
    .sel_data    (sel_data)
  );

  cfg_word_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .take_dbg  (take_dbg),
    .sel_data  (sel_data),
    .word_q    (cfg_data),
    .src_dbg_q (src_dbg_q)
  );

  assign cfg_valid = busy;
endmodule

// File: rtl/cfg_word_pacer_chk.sv
module cfg_word_pacer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RATIO  = 1,
  parameter int unsigned CNT_W  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              dbg_engaged,
  input logic              dbg_ready,
  input logic              s_ready,
  input logic [DATA_W-1:0] cfg_data,
  input logic              cfg_valid,
  input logic              hold_last,
  input logic [CNT_W-1:0]  hold_cnt,
  input logic              take,
  input logic [DATA_W-1:0] sel_data,
  input logic              src_dbg_q
);
  p_no_std_ready_r7: assert property (@(posedge clk) disable iff (rst)
    dbg_engaged |-> !s_ready);

  p_no_dbg_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !dbg_engaged |-> !dbg_ready);

  p_ready_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    (s_ready || dbg_ready) |-> (!cfg_valid || hold_last));

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !hold_last) |=> (cfg_valid && $stable(cfg_data)));

  p_accept_lands_r5: assert property (@(posedge clk) disable iff (rst)
    take |=> (cfg_valid && cfg_data == $past(sel_data)));

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (hold_cnt <= CNT_W'(RATIO - 1)));

  p_src_fixed_mid_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !hold_last) |=> $stable(src_dbg_q));

  p_reset_empty_r10: assert property (@(posedge clk)
    $past(rst) |-> !cfg_valid);
endmodule

bind cfg_word_pacer cfg_word_pacer_chk #(
  .DATA_W (DATA_W),
  .RATIO  (RATIO),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dbg_engaged (dbg_engaged),
  .dbg_ready   (dbg_ready),
  .s_ready     (s_ready),
  .cfg_data    (cfg_data),
  .cfg_valid   (cfg_valid),
  .hold_last   (hold_last),
  .hold_cnt    (hold_cnt),
  .take        (take),
  .sel_data    (sel_data),
  .src_dbg_q   (src_dbg_q)
);

// File: tb/cfg_word_pacer_bench.sv
module cfg_word_pacer_bench;
  localparam int DW = 16;
  localparam int NCFG = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          dbg_en = 1'b0, dbg_valid = 1'b0, s_valid = 1'b0;
  logic [DW-1:0] dbg_data = '0, s_data = '0;

  logic [DW-1:0] od   [NCFG];
  logic          ov   [NCFG];
  logic          srdy [NCFG];
  logic          drdy [NCFG];

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    logic [DW-1:0] d;
    logic v, sr, dr;
    cfg_word_pacer #(
      .DATA_W(DW), .COMPRESSED(g >= 2), .ENCRYPTED(g % 2 == 1)
    ) u_cfg_word_pacer (
      .clk(clk), .rst(rst),
      .dbg_engaged(dbg_en), .dbg_valid(dbg_valid), .dbg_data(dbg_data), .dbg_ready(dr),
      .s_valid(s_valid), .s_data(s_data), .s_ready(sr),
      .cfg_data(d), .cfg_valid(v)
    );
    assign od[g] = d;
    assign ov[g] = v;
    assign srdy[g] = sr;
    assign drdy[g] = dr;
  end

  int checks = 0, failures = 0;
  string hold_tag = "R5";

  // Ratio from the flags: index bit 1 = compressed, bit 0 = encrypted.
  function automatic int exp_ratio(input int g);
    bit c = (g >= 2);
    bit e = (g % 2 == 1);
    if (!c && !e) return 1;
    if (!c) return 2;
    return 4;
  endfunction

  task automatic check(input bit ok, input string req, input int g,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cfg%0d actual=%0d expected=%0d t=%0t", req, g, act, exp, $time);
    end
  endtask

  // Independent scoreboard, sampled at the falling edge.
  int            hold_left [NCFG];
  logic [DW-1:0] exp_w     [NCFG];
  int            acc_cnt   [NCFG];

  always @(negedge clk) begin
    for (int g = 0; g < NCFG; g++) begin
      if (rst) begin
        hold_left[g] = 0;
      end else begin
        logic sv, rdy;
        logic [DW-1:0] sd;
        sv  = dbg_en ? dbg_valid : s_valid;
        rdy = dbg_en ? drdy[g] : srdy[g];
        sd  = dbg_en ? dbg_data : s_data;
        if (hold_left[g] > 0) begin
          check(ov[g] && od[g] == exp_w[g], hold_tag, g, int'(od[g]), int'(exp_w[g]));
          hold_left[g]--;
        end else begin
          check(!ov[g], "R9", g, int'(ov[g]), 0);
        end
        check(!(dbg_en && srdy[g]) && !(!dbg_en && drdy[g]), "R7", g,
              int'(srdy[g]) * 2 + int'(drdy[g]), dbg_en ? 1 : 2);
        check(rdy == (hold_left[g] == 0), "R6", g, int'(rdy), int'(hold_left[g] == 0));
        if (rdy && sv) begin
          exp_w[g]     = sd;
          hold_left[g] = exp_ratio(g);
          acc_cnt[g]++;
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      s_data   = s_data + 16'd1;
      dbg_data = dbg_data + 16'd1;
    end
  endtask

  task automatic clear_acc();
    for (int g = 0; g < NCFG; g++) acc_cnt[g] = 0;
  endtask

  bit done = 1'b0;

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    dbg_data = 16'hD000;
    s_data   = 16'h0100;
    tick(4);
    rst = 1'b0;
    tick(1);
    // R10: empty output and open slot after reset
    for (int g = 0; g < NCFG; g++) begin
      check(!ov[g], "R10", g, int'(ov[g]), 0);
      check(srdy[g], "R10", g, int'(srdy[g]), 1);
    end

    // Ratio sweep over all four flag combinations (R1..R4)
    clear_acc();
    s_valid = 1'b1;
    tick(40);
    s_valid = 1'b0;
    check(acc_cnt[0] == 40, "R1", 0, acc_cnt[0], 40);
    check(acc_cnt[1] == 20, "R2", 1, acc_cnt[1], 20);
    check(acc_cnt[2] == 10, "R3", 2, acc_cnt[2], 10);
    check(acc_cnt[3] == 10, "R4", 3, acc_cnt[3], 10);

    // Producer idle: output drains (R9)
    tick(6);
    for (int g = 0; g < NCFG; g++) check(!ov[g], "R9", g, int'(ov[g]), 0);

    // Debug producer engaged with both producers valid (R7)
    clear_acc();
    dbg_en = 1'b1;
    dbg_valid = 1'b1;
    s_valid = 1'b1;
    tick(40);
    for (int g = 0; g < NCFG; g++)
      check(acc_cnt[g] == 40 / exp_ratio(g), "R7", g, acc_cnt[g], 40 / exp_ratio(g));

    // Debug engaged but idle: normal stream must be ignored (R7)
    clear_acc();
    dbg_valid = 1'b0;
    tick(8);
    for (int g = 0; g < NCFG; g++) begin
      check(acc_cnt[g] == 0, "R7", g, acc_cnt[g], 0);
      check(!ov[g], "R7", g, int'(ov[g]), 0);
    end

    // Switch producer partway through a hold (R8)
    dbg_en = 1'b0;
    dbg_valid = 1'b1;
    tick(5);
    hold_tag = "R8";
    dbg_en = 1'b1;
    tick(11);
    dbg_en = 1'b0;
    tick(10);
    hold_tag = "R5";

    // Reset in the middle of streaming (R10)
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    for (int g = 0; g < NCFG; g++) check(!ov[g], "R10", g, int'(ov[g]), 0);
    s_valid = 1'b0;
    dbg_valid = 1'b0;
    tick(6);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule